// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block copies a run of words between one peripheral data port and memory without the processor touching each word. Software programs three registers: a base address, a word count and a control/status word. It then writes the control word with the go bit set. The engine asks for the memory bus, moves one word on every granted cycle and advances the address by one. It reports completion through a done flag and, if interrupts are enabled, through an interrupt line.

The direction bit chooses the data path. With the bit clear, words flow from the peripheral into memory. With the bit set, they flow from memory out to the peripheral.

A policy bit chooses how the engine uses the bus. In steal mode the request is dropped after every word, so the processor can get a cycle in between. In burst mode the request is held until the last word. The external arbiter gives this request precedence over the processor.

Top module: `dma_engine`

## Requirements
- R1: After reset every register reads as zero, `mem_req` is low and `irq` is low.
- R2: A go write while idle copies the base address and count into the sequencer. The first request appears in the next cycle at the base address, and each granted word is at the previous word's address plus one.
- R3: With the direction bit (control bit 1) at 0, each granted cycle has `mem_we`=1, `mem_wdata` equal to `dev_rdata` and a one-cycle `dev_rd` strobe. With it at 1, each granted cycle has `dev_wdata` equal to `mem_rdata` and a one-cycle `dev_wr` strobe. Neither strobe fires outside a granted cycle.
- R4: In steal mode (control bit 2 at 0), `mem_req` is low for exactly one cycle after each granted word that is not the last.
- R5: In burst mode (control bit 2 at 1), `mem_req` stays high from the first request until the last word is granted.
- R6: While `mem_gnt` is low, a pending request stays asserted and the address does not move.
- R7: Exactly the programmed number of words is moved. The done flag (status bit 0) reads 1 from the cycle after the last grant, and the busy flag (status bit 3) reads 0 at that point.
- R8: A go write with a count of zero sets done in the next cycle and never raises `mem_req`.
- R9: At completion the IRQ bit (status bit 31) and the `irq` pin rise if the enable bit (control bit 30) is 1, and stay low otherwise.
- R10: IRQ is cleared by writing 1 to control bit 31 or by reading the status register (offset 2). If a completion falls in the same cycle as either clear, IRQ ends up set.
- R11: While a transfer is in progress, go writes and writes to the direction, policy and enable bits are ignored. Register offsets are 0 for address, 1 for count and 2 for control/status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a status read clears IRQ) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory bus request |
| mem_gnt | input | 1 | Memory bus grant; a word moves when request and grant are both high |
| mem_addr | output | ADDR_W | Word address of the current access |
| mem_we | output | 1 | Memory write enable (direction bit at 0) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the granted cycle |
| dev_rdata | input | DATA_W | Word offered by the peripheral |
| dev_rd | output | 1 | Peripheral word consumed this cycle |
| dev_wdata | output | DATA_W | Word delivered to the peripheral |
| dev_wr | output | 1 | Peripheral word delivered this cycle |

## Verification
Two events can land in the same cycle: a transfer completing and software clearing the interrupt. The bench holds the grant low on a one-word transfer. It then raises the grant in the same cycle as a status read, and again in the same cycle as a write-one-to-clear of bit 31. In both cases `irq` must be high afterwards, because the new completion outranks the clear. A later clear must then drop it. The bench also sweeps direction, bus policy, interrupt enable, grant pattern and word count. It checks request timing, addresses and data routing cycle by cycle against an arithmetic model.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_REQ  = 2'd1,
        MV_GAP  = 2'd2
    } mv_state_e;

    localparam logic [1:0] OFS_ADDR = 2'd0;
    localparam logic [1:0] OFS_CNT  = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    localparam int BIT_DONE  = 0;
    localparam int BIT_RW    = 1;
    localparam int BIT_BURST = 2;
    localparam int BIT_GO    = 3;
    localparam int BIT_IE    = 30;
    localparam int BIT_IRQ   = 31;

endpackage

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              rw,
    input  logic              burst,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic              busy,
    output logic              finish
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        mv_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } mv_t;

    mv_t  mv_d, mv_q;
    logic xfer;

    always_comb begin
        mv_d   = mv_q;
        finish = 1'b0;
        xfer   = (mv_q.st == MV_REQ) && mem_gnt;
        case (mv_q.st)
            MV_IDLE: begin
                if (start) begin
                    mv_d.addr = start_addr;
                    mv_d.cnt  = start_cnt;
                    if (start_cnt == '0) finish  = 1'b1;
                    else                 mv_d.st = MV_REQ;
                end
            end
            MV_REQ: begin
                if (mem_gnt) begin
                    mv_d.addr = mv_q.addr + ADDR_ONE;
                    mv_d.cnt  = mv_q.cnt - CNT_ONE;
                    if (mv_q.cnt == CNT_ONE) begin
                        mv_d.st = MV_IDLE;
                        finish  = 1'b1;
                    end else if (!burst) begin
                        mv_d.st = MV_GAP;
                    end
                end
            end
            MV_GAP:  mv_d.st = MV_REQ;
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '{st: MV_IDLE, addr: '0, cnt: '0};
        else        mv_q <= mv_d;
    end

    assign mem_req   = (mv_q.st == MV_REQ);
    assign mem_addr  = mv_q.addr;
    assign mem_we    = !rw;
    assign mem_wdata = dev_rdata;
    assign dev_wdata = mem_rdata;
    assign dev_rd    = xfer && !rw;
    assign dev_wr    = xfer && rw;
    assign busy      = (mv_q.st != MV_IDLE);

    assert_steal_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !burst) |=> !mem_req);

    assert_burst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && burst && mv_q.cnt != CNT_ONE) |=> mem_req);

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> (mem_addr == $past(mem_addr) + ADDR_ONE));

    assert_finish_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !mem_req);

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              finish,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  start_cnt,
    output logic              rw,
    output logic              burst,
    output logic              irq
);

    typedef struct packed {
        logic [ADDR_W-1:0] saddr;
        logic [CNT_W-1:0]  scnt;
        logic              rw;
        logic              burst;
        logic              ie;
        logic              done;
        logic              irq;
    } rg_t;

    rg_t  rg_d, rg_q;
    logic wr_ctrl;
    logic rd_ctrl;

    always_comb begin
        rg_d    = rg_q;
        start   = 1'b0;
        wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
        rd_ctrl = reg_re && (reg_addr == OFS_CTRL);
        if (reg_we && reg_addr == OFS_ADDR) rg_d.saddr = reg_wdata[ADDR_W-1:0];
        if (reg_we && reg_addr == OFS_CNT)  rg_d.scnt  = reg_wdata[CNT_W-1:0];
        if (wr_ctrl && !busy) begin
            rg_d.rw    = reg_wdata[BIT_RW];
            rg_d.burst = reg_wdata[BIT_BURST];
            rg_d.ie    = reg_wdata[BIT_IE];
            if (reg_wdata[BIT_GO]) begin
                start     = 1'b1;
                rg_d.done = 1'b0;
                rg_d.irq  = 1'b0;
            end
        end
        if ((wr_ctrl && reg_wdata[BIT_IRQ]) || rd_ctrl) rg_d.irq = 1'b0;
        if (finish) begin
            rg_d.done = 1'b1;
            if (rg_d.ie) rg_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ADDR: reg_rdata = 32'(rg_q.saddr);
            OFS_CNT:  reg_rdata = 32'(rg_q.scnt);
            OFS_CTRL: begin
                reg_rdata[BIT_DONE]  = rg_q.done;
                reg_rdata[BIT_RW]    = rg_q.rw;
                reg_rdata[BIT_BURST] = rg_q.burst;
                reg_rdata[BIT_GO]    = busy;
                reg_rdata[BIT_IE]    = rg_q.ie;
                reg_rdata[BIT_IRQ]   = rg_q.irq;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign start_addr = rg_q.saddr;
    assign start_cnt  = rg_q.scnt;
    assign rw         = rg_q.rw;
    assign burst      = rg_q.burst;
    assign irq        = rg_q.irq;

    assert_irq_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rg_q.done);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rg_q.done && busy));

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(rw) && $stable(burst)));

    assert_finish_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && rg_d.ie) |=> irq);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_rd,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_wr
);

    logic              start, busy, finish, rw, burst;
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  start_cnt;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .finish     (finish),
        .start      (start),
        .start_addr (start_addr),
        .start_cnt  (start_cnt),
        .rw         (rw),
        .burst      (burst),
        .irq        (irq)
    );

    dma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) mover_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .start_cnt  (start_cnt),
        .rw         (rw),
        .burst      (burst),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .dev_rdata  (dev_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .dev_wdata  (dev_wdata),
        .dev_wr     (dev_wr),
        .dev_rd     (dev_rd),
        .busy       (busy),
        .finish     (finish)
    );

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[29:4], reg_wdata[0]};

endmodule

// File: tb/dma_engine_tb_top.sv
`timescale 1ns/1ps
module dma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we, dev_rd, dev_wr;
    logic        mem_gnt = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, dev_wdata;
    logic [31:0] dev_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    assign mem_rdata = {16'h5A5A, mem_addr};

    dma_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_rdata(dev_rdata), .dev_rd(dev_rd), .dev_wdata(dev_wdata),
        .dev_wr(dev_wr)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v, output logic irq_s);
        reg_re = 1'b1; reg_addr = a;
        #1;
        v = reg_rdata; irq_s = irq;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(bit go, bit rw, bit burst, bit ie, bit w1c);
        return (32'(w1c) << 31) | (32'(ie) << 30) | (32'(go) << 3) | (32'(burst) << 2) | (32'(rw) << 1);
    endfunction

    task automatic run_xfer(input logic [15:0] base, input int cnt, input bit rw,
                            input bit burst, input bit ie, input int gmode);
        int   words = 0;
        int   cyc = 0;
        bit   exp_req, gap, fin;
        logic [31:0] st;
        logic irq_s;
        gap = 1'b0;
        wr_reg(2'd0, 32'(base));
        wr_reg(2'd1, 32'(cnt));
        wr_reg(2'd2, ctrl_word(1'b1, rw, burst, ie, 1'b0));
        exp_req = (cnt != 0);
        fin     = (cnt == 0);
        if (cnt == 0) begin
            #1;
            chk("R8 no request on zero count", 32'(mem_req), 32'd0);
        end
        while (!fin && cyc < 200) begin
            mem_gnt   = (gmode == 0) ? 1'b1 : (cyc % 3 == 2);
            dev_rdata = 32'hD000_0000 + 32'(cyc) + 32'(words) * 32'h100;
            #1;
            if (exp_req && !mem_gnt)
                chk("R6 request held while waiting", 32'(mem_req), 32'(exp_req));
            else if (burst)
                chk("R5 burst request", 32'(mem_req), 32'(exp_req));
            else
                chk("R4 steal request", 32'(mem_req), 32'(exp_req));
            if (exp_req && mem_gnt) begin
                chk("R2 word address", 32'(mem_addr), 32'(base + 16'(words)));
                if (rw) begin
                    chk("R3 memory to device data", dev_wdata, {16'h5A5A, base + 16'(words)});
                    chk("R3 device write strobe", {30'd0, dev_wr, dev_rd}, 32'd2);
                end else begin
                    chk("R3 device to memory data", mem_wdata, dev_rdata);
                    chk("R3 device read strobe", {30'd0, mem_we, dev_rd}, 32'd3);
                    chk("R3 no device write", 32'(dev_wr), 32'd0);
                end
                words++;
                if (words == cnt) begin
                    fin = 1'b1; exp_req = 1'b0;
                end else if (!burst) begin
                    exp_req = 1'b0; gap = 1'b1;
                end
            end else begin
                chk("R3 no strobe without grant", {30'd0, dev_wr, dev_rd}, 32'd0);
                if (gap) begin
                    gap = 1'b0; exp_req = 1'b1;
                end
            end
            @(negedge clk);
            cyc++;
        end
        mem_gnt = 1'b0;
        chk("R7 word total", 32'(words), 32'(cnt));
        rd_reg(2'd2, st, irq_s);
        chk("R7 done and idle", {30'd0, st[3], st[0]}, 32'd1);
        chk("R9 irq status bit", 32'(st[31]), 32'(ie));
        chk("R9 irq pin", 32'(irq_s), 32'(ie));
        #1;
        chk("R10 read clears irq", 32'(irq), 32'd0);
        @(negedge clk);
    endtask

    task automatic collide(input bit by_write);
        logic [31:0] st;
        logic irq_s;
        wr_reg(2'd0, 32'h0300);
        wr_reg(2'd1, 32'd1);
        wr_reg(2'd2, ctrl_word(1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
        @(negedge clk);
        #1;
        chk("R6 waiting for grant", 32'(mem_req), 32'd1);
        @(negedge clk);
        mem_gnt = 1'b1;
        if (by_write) begin
            reg_we = 1'b1; reg_addr = 2'd2;
            reg_wdata = ctrl_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        end else begin
            reg_re = 1'b1; reg_addr = 2'd2;
        end
        @(negedge clk);
        mem_gnt = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_wdata = '0;
        #1;
        chk(by_write ? "R10 set beats write clear" : "R10 set beats read clear", 32'(irq), 32'd1);
        @(negedge clk);
        wr_reg(2'd2, ctrl_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        #1;
        chk("R10 write one clears irq", 32'(irq), 32'd0);
        rd_reg(2'd2, st, irq_s);
        chk("R10 done kept after clear", 32'(st[0]), 32'd1);
    endtask

    initial begin
        logic [31:0] v;
        logic irq_s;
        int idx = 0;
        int strobes;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 reset request", 32'(mem_req), 32'd0);
        chk("R1 reset irq", 32'(irq), 32'd0);
        for (int a = 0; a < 3; a++) begin
            rd_reg(2'(a), v, irq_s);
            chk("R1 reset register", v, 32'd0);
        end

        for (int rw = 0; rw < 2; rw++)
            for (int bu = 0; bu < 2; bu++)
                for (int ie = 0; ie < 2; ie++)
                    for (int gm = 0; gm < 2; gm++)
                        for (int ci = 0; ci < 5; ci++) begin
                            int cnts[5] = '{0, 1, 2, 3, 6};
                            run_xfer(16'h0100 + 16'(idx * 16), cnts[ci], rw[0], bu[0], ie[0], gm);
                            idx++;
                        end

        collide(1'b0);
        collide(1'b1);

        // R11: go and config writes ignored while a transfer is pending
        wr_reg(2'd0, 32'h0700);
        wr_reg(2'd1, 32'd3);
        wr_reg(2'd2, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        wr_reg(2'd0, 32'h0900);
        wr_reg(2'd2, ctrl_word(1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
        rd_reg(2'd2, v, irq_s);
        chk("R11 config kept while busy", {28'd0, v[3:0]}, 32'h8);
        chk("R11 enable kept while busy", 32'(v[30]), 32'd0);
        #1;
        chk("R11 address unaffected", 32'(mem_addr), 32'h0700);
        strobes = 0;
        mem_gnt = 1'b1;
        for (int k = 0; k < 10; k++) begin
            #1;
            if (dev_rd || dev_wr) strobes++;
            @(negedge clk);
        end
        mem_gnt = 1'b0;
        chk("R11 original count moved", 32'(strobes), 32'd3);
        rd_reg(2'd2, v, irq_s);
        chk("R11 done without irq", {v[31], 30'd0, v[0]}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule